// File: doc/BRIEF.md
# Address Break Comparator Unit

The block watches the per-cycle bus of a 16-bit processor, which has a 16-bit address and a data word carried on an upper and a lower 8-bit lane. When a bus cycle of the selected kind hits the programmed break address, and the selected data lanes hold the programmed break data, the block sets a sticky break flag. While the break enable bit is also set, it raises an interrupt request. A debugger programs the break condition and services the flag through a byte-wide register port.

A byte access, or any access to an I/O register that has an 8-bit data path, carries its byte on the upper lane only. In that case the bus address must equal the break address exactly. A word access to ROM, RAM or a 16-bit I/O register carries the even byte on the upper lane and the odd byte on the lower lane. It therefore hits a break address that names either byte of the word. The lower-lane data comparison can succeed only on such a word access. The break flag is cleared by a two-step sequence: the flag must first be read as 1, and a 0 must then be written to it.

Top module: `addr_break_unit`

## Requirements
- R1: After reset, the status register reads 0x3F, the break address reads 0xFF at offset 2 and 0xFF at offset 3, the break data reads 0x00 at offsets 4 and 5, the control register reads 0x00, and irq is 0.
- R2: The host register offsets are: 0 status, 1 control, 2 break address high byte, 3 break address low byte, 4 break data high byte, 5 break data low byte. Offsets 6 and 7 read 0x00. Status bits 5..0 always read 1. Control bits 7..4 read 0. Read data appears on hst_rdata one clock after the clock edge that samples hst_rd.
- R3: Control bits 1..0 select the kind of cycle that can hit. The encodings are: 0 instruction fetch (bus_fetch=1, bus_write=0), 1 data read (bus_fetch=0, bus_write=0), 2 data write (bus_write=1), 3 data read or data write (bus_fetch=0).
- R4: A cycle is wide when bus_word=1 and bus_space is not 3 (the spaces are 0 ROM, 1 RAM, 2 16-bit I/O, 3 8-bit I/O). A wide cycle hits the address when bus_addr[15:1] equals break address bits 15..1. Any other cycle needs bus_addr to equal the break address exactly.
- R5: Control bits 3..2 select the data comparison: 0 none, 1 upper lane, 2 lower lane, 3 both lanes. The upper check compares bus_data[15:8] with the break data high byte. The lower check compares bus_data[7:0] with the break data low byte, and it fails on any cycle that is not wide.
- R6: The break flag (status bit 7) is set at the clock edge that samples a hitting cycle with bus_valid=1. Once set, later non-hitting cycles do not clear it.
- R7: A host write to status with bit 7 = 0 clears the flag only if a status read since the last status write returned the flag as 1. Any status write ends that armed condition. Writing 1 to bit 7 never sets the flag. Bit 6 is the enable bit, and every status write loads it.
- R8: irq is registered and equals flag AND enable, taking the values that both bits hold after the same clock edge.
- R9: When a hitting bus cycle and an armed clearing write fall on the same clock edge, the flag stays set, and the write still ends the armed condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr | input | 1 | Host register write strobe |
| hst_rd | input | 1 | Host register read strobe |
| hst_addr | input | 3 | Host register offset |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Registered host read data |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 16 | Bus cycle address |
| bus_data | input | 16 | Bus data, upper lane [15:8], lower lane [7:0] |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| bus_write | input | 1 | 1 = write cycle |
| bus_fetch | input | 1 | 1 = instruction fetch cycle |
| bus_space | input | 2 | Target space: 0 ROM, 1 RAM, 2 16-bit I/O, 3 8-bit I/O |
| irq | output | 1 | Break interrupt request |

## Verification
The break hit that sets the flag and the armed host write that clears it can fall on the same clock edge. The bench provokes this collision by reading the set flag, which arms the clear, and then driving the clearing write and a hitting fetch in the same cycle. It judges the result by reading the flag back as still set. It then writes 0 again without a fresh read and expects the flag to survive, which proves the collided write used up the arm. A read followed by a write of 0 must then clear the flag.

// File: rtl/abk_pkg.sv
package abk_pkg;
  typedef enum logic [1:0] {
    CYC_FETCH = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_ANY   = 2'd3
  } cyc_sel_e;

  localparam logic [1:0] SPACE_IO8 = 2'd3;

  localparam logic [2:0] OFS_STAT = 3'd0;
  localparam logic [2:0] OFS_CTRL = 3'd1;
  localparam logic [2:0] OFS_BAH  = 3'd2;
  localparam logic [2:0] OFS_BAL  = 3'd3;
  localparam logic [2:0] OFS_BDH  = 3'd4;
  localparam logic [2:0] OFS_BDL  = 3'd5;

  typedef struct packed {
    logic [1:0] dmode;
    cyc_sel_e   csel;
  } ctrl_t;
endpackage

// File: rtl/abk_regfile.sv
module abk_regfile
  import abk_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int HA_W   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic                rd,
  input  logic [HA_W-1:0]     addr,
  input  logic [LANE_W-1:0]   wdata,
  input  logic                flag,
  output logic [LANE_W-1:0]   rdata_q,
  output logic [2*LANE_W-1:0] brk_addr,
  output logic [2*LANE_W-1:0] brk_data,
  output ctrl_t               ctrl,
  output logic                en_q,
  output logic                en_nx,
  output logic                st_wr,
  output logic                st_rd,
  output logic                wflag
);
  localparam int RES_W = LANE_W - 2;

  logic [LANE_W-1:0] bah_q, bal_q, bdh_q, bdl_q;
  ctrl_t             ctrl_q;
  logic [LANE_W-1:0] rd_mux;

  assign st_wr = wr && (addr == HA_W'(OFS_STAT));
  assign st_rd = rd && (addr == HA_W'(OFS_STAT));
  assign wflag = wdata[LANE_W-1];
  assign en_nx = st_wr ? wdata[LANE_W-2] : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bah_q  <= '1;
      bal_q  <= '1;
      bdh_q  <= '0;
      bdl_q  <= '0;
      ctrl_q <= '0;
      en_q   <= 1'b0;
    end else begin
      en_q <= en_nx;
      if (wr) begin
        case (addr)
          HA_W'(OFS_CTRL): ctrl_q <= ctrl_t'(wdata[3:0]);
          HA_W'(OFS_BAH):  bah_q  <= wdata;
          HA_W'(OFS_BAL):  bal_q  <= wdata;
          HA_W'(OFS_BDH):  bdh_q  <= wdata;
          HA_W'(OFS_BDL):  bdl_q  <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      HA_W'(OFS_STAT): rd_mux = {flag, en_q, {RES_W{1'b1}}};
      HA_W'(OFS_CTRL): rd_mux = LANE_W'(ctrl_q);
      HA_W'(OFS_BAH):  rd_mux = bah_q;
      HA_W'(OFS_BAL):  rd_mux = bal_q;
      HA_W'(OFS_BDH):  rd_mux = bdh_q;
      HA_W'(OFS_BDL):  rd_mux = bdl_q;
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign brk_addr = {bah_q, bal_q};
  assign brk_data = {bdh_q, bdl_q};
  assign ctrl     = ctrl_q;

  p_en_load_r7: assert property (@(posedge clk) disable iff (rst)
    st_wr |=> (en_q == $past(wdata[LANE_W-2])));
  p_en_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !st_wr |=> $stable(en_q));
endmodule

// File: rtl/abk_match.sv
module abk_match
  import abk_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_valid,
  input  logic [2*LANE_W-1:0] bus_addr,
  input  logic [2*LANE_W-1:0] bus_data,
  input  logic                bus_word,
  input  logic                bus_write,
  input  logic                bus_fetch,
  input  logic [1:0]          bus_space,
  input  logic [2*LANE_W-1:0] brk_addr,
  input  logic [2*LANE_W-1:0] brk_data,
  input  ctrl_t               ctrl,
  output logic                hit
);
  localparam int AW    = 2 * LANE_W;
  localparam int LANES = 2;

  logic             wide;
  logic             cyc_ok, addr_ok;
  logic [LANES-1:0] lane_live, lane_need, lane_ok;

  assign wide = bus_word && (bus_space != SPACE_IO8);

  always_comb begin
    case (ctrl.csel)
      CYC_FETCH: cyc_ok = bus_fetch && !bus_write;
      CYC_READ:  cyc_ok = !bus_fetch && !bus_write;
      CYC_WRITE: cyc_ok = bus_write;
      default:   cyc_ok = !bus_fetch;
    endcase
  end

  assign addr_ok = wide ? (bus_addr[AW-1:1] == brk_addr[AW-1:1])
                        : (bus_addr == brk_addr);

  // lane 1 = upper byte lane, lane 0 = lower byte lane
  assign lane_live = {1'b1, wide};
  assign lane_need = {ctrl.dmode[0], ctrl.dmode[1]};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic eq;
    assign eq         = bus_data[l*LANE_W +: LANE_W] == brk_data[l*LANE_W +: LANE_W];
    assign lane_ok[l] = !lane_need[l] || (lane_live[l] && eq);
  end

  assign hit = bus_valid && cyc_ok && addr_ok && (&lane_ok);

  p_lower_narrow_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrl.dmode[1] && !wide) |-> !hit);
  p_fetch_sel_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl.csel == CYC_FETCH && !bus_fetch) |-> !hit);
endmodule

// File: rtl/abk_flag.sv
module abk_flag (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic st_rd,
  input  logic st_wr,
  input  logic wflag,
  input  logic en_nx,
  output logic flag_q,
  output logic irq_q
);
  logic armed_q;
  logic clr;
  logic flag_n;

  assign clr    = st_wr && !wflag && armed_q;
  assign flag_n = hit || (flag_q && !clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      flag_q <= flag_n;
      irq_q  <= flag_n && en_nx;
      if (st_wr)               armed_q <= 1'b0;
      else if (st_rd && flag_q) armed_q <= 1'b1;
    end
  end

  p_set_r6: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag_q);
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !st_wr) |=> flag_q);
  p_unarmed_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_q && st_wr && !armed_q) |=> flag_q);
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (st_wr && !wflag && armed_q && !hit) |=> !flag_q);
  p_arm_spent_r9: assert property (@(posedge clk) disable iff (rst)
    st_wr |=> !armed_q);
endmodule

// File: rtl/addr_break_unit.sv
module addr_break_unit
  import abk_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int HA_W   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hst_wr,
  input  logic                hst_rd,
  input  logic [HA_W-1:0]     hst_addr,
  input  logic [LANE_W-1:0]   hst_wdata,
  output logic [LANE_W-1:0]   hst_rdata,
  input  logic                bus_valid,
  input  logic [2*LANE_W-1:0] bus_addr,
  input  logic [2*LANE_W-1:0] bus_data,
  input  logic                bus_word,
  input  logic                bus_write,
  input  logic                bus_fetch,
  input  logic [1:0]          bus_space,
  output logic                irq
);
  localparam int W2 = 2 * LANE_W;

  logic [W2-1:0] brk_addr, brk_data;
  ctrl_t         ctrl;
  logic          en_q, en_nx, st_wr, st_rd, wflag;
  logic          hit, flag_q, irq_q;

  abk_regfile #(.LANE_W(LANE_W), .HA_W(HA_W)) i_regs (
    .clk(clk), .rst(rst), .wr(hst_wr), .rd(hst_rd), .addr(hst_addr),
    .wdata(hst_wdata), .flag(flag_q), .rdata_q(hst_rdata),
    .brk_addr(brk_addr), .brk_data(brk_data), .ctrl(ctrl),
    .en_q(en_q), .en_nx(en_nx), .st_wr(st_wr), .st_rd(st_rd), .wflag(wflag)
  );

  abk_match #(.LANE_W(LANE_W)) i_match (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_word(bus_word), .bus_write(bus_write),
    .bus_fetch(bus_fetch), .bus_space(bus_space), .brk_addr(brk_addr),
    .brk_data(brk_data), .ctrl(ctrl), .hit(hit)
  );

  abk_flag i_flag (
    .clk(clk), .rst(rst), .hit(hit), .st_rd(st_rd), .st_wr(st_wr),
    .wflag(wflag), .en_nx(en_nx), .flag_q(flag_q), .irq_q(irq_q)
  );

  assign irq = irq_q;

  p_irq_off_r8: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !irq);
  p_irq_on_r8: assert property (@(posedge clk) disable iff (rst)
    (en_q && flag_q) |-> irq);
endmodule

// File: tb/test_addr_break_unit.sv
module test_addr_break_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_wr = 0, hst_rd = 0;
  logic [2:0]  hst_addr = 0;
  logic [7:0]  hst_wdata = 0;
  logic [7:0]  hst_rdata;
  logic        bus_valid = 0;
  logic [15:0] bus_addr = 0, bus_data = 0;
  logic        bus_word = 0, bus_write = 0, bus_fetch = 0;
  logic [1:0]  bus_space = 0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  addr_break_unit i_addr_break_unit (
    .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_word(bus_word), .bus_write(bus_write), .bus_fetch(bus_fetch),
    .bus_space(bus_space), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hst_wr = 1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr = 0;
  endtask

  task automatic hread(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    hst_rd = 1; hst_addr = a;
    @(negedge clk);
    hst_rd = 0;
    d = hst_rdata;
  endtask

  task automatic bus_cyc(input logic [15:0] a, input logic [15:0] d, input logic w,
                         input logic wr, input logic f, input logic [1:0] sp);
    @(negedge clk);
    bus_valid = 1; bus_addr = a; bus_data = d; bus_word = w;
    bus_write = wr; bus_fetch = f; bus_space = sp;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic set_bar(input logic [15:0] b);
    hwrite(3'd2, b[15:8]);
    hwrite(3'd3, b[7:0]);
  endtask

  task automatic clear_flag(input logic [7:0] wr_val);
    logic [7:0] tmp;
    hread(3'd0, tmp);
    hwrite(3'd0, wr_val);
  endtask

  function automatic logic exp_hit(input logic [1:0] csel, input logic [1:0] dmode,
      input logic [15:0] bar, input logic [15:0] bdr, input logic [15:0] a,
      input logic [15:0] d, input logic w, input logic wr, input logic f,
      input logic [1:0] sp);
    logic wide, cyc, aok, uok, lok;
    wide = w && (sp != 2'd3);
    case (csel)
      2'd0: cyc = f && !wr;
      2'd1: cyc = !f && !wr;
      2'd2: cyc = wr;
      default: cyc = !f;
    endcase
    aok = wide ? ((a >> 1) == (bar >> 1)) : (a == bar);
    uok = !dmode[0] || (d[15:8] == bdr[15:8]);
    lok = !dmode[1] || (wide && d[7:0] == bdr[7:0]);
    return cyc && aok && uok && lok;
  endfunction

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset values
    check("R1 irq", {15'b0, irq}, 16'h0);
    hread(3'd0, rv); check("R1 status", {8'h0, rv}, 16'h003F);
    hread(3'd1, rv); check("R1 ctrl", {8'h0, rv}, 16'h0000);
    hread(3'd2, rv); check("R1 bah", {8'h0, rv}, 16'h00FF);
    hread(3'd3, rv); check("R1 bal", {8'h0, rv}, 16'h00FF);
    hread(3'd4, rv); check("R1 bdh", {8'h0, rv}, 16'h0000);
    hread(3'd5, rv); check("R1 bdl", {8'h0, rv}, 16'h0000);

    // R2 map and readback
    hwrite(3'd1, 8'hFF); hread(3'd1, rv); check("R2 ctrl mask", {8'h0, rv}, 16'h000F);
    hwrite(3'd4, 8'hC3); hread(3'd4, rv); check("R2 bdh", {8'h0, rv}, 16'h00C3);
    hwrite(3'd5, 8'h3C); hread(3'd5, rv); check("R2 bdl", {8'h0, rv}, 16'h003C);
    hwrite(3'd6, 8'hAA); hread(3'd6, rv); check("R2 unmapped6", {8'h0, rv}, 16'h0000);
    hread(3'd7, rv); check("R2 unmapped7", {8'h0, rv}, 16'h0000);

    // R6 timing and R8 irq: fetch break at 0x0100, enable on
    hwrite(3'd1, 8'h00);
    set_bar(16'h0100);
    hwrite(3'd0, 8'h40);
    @(negedge clk);
    bus_valid = 1; bus_addr = 16'h0100; bus_word = 1; bus_write = 0;
    bus_fetch = 1; bus_space = 2'd0;
    #1 check("R6 before edge", {15'b0, irq}, 16'h0);
    @(negedge clk);
    bus_valid = 0;
    check("R6 R8 irq after edge", {15'b0, irq}, 16'h1);
    bus_cyc(16'h2000, 16'h0, 1, 0, 1, 2'd0);
    hread(3'd0, rv); check("R6 sticky", {8'h0, rv}, 16'h00FF);

    // R7 unarmed clear: status write (consumes arm from read above) then 0 without read
    hwrite(3'd0, 8'hC0);
    hwrite(3'd0, 8'h40);
    check("R7 unarmed irq", {15'b0, irq}, 16'h1);
    hread(3'd0, rv); check("R7 unarmed flag", {8'h0, rv}, 16'h00FF);
    hwrite(3'd0, 8'h40);
    hread(3'd0, rv); check("R7 armed clear", {8'h0, rv}, 16'h007F);
    check("R7 irq cleared", {15'b0, irq}, 16'h0);
    hwrite(3'd0, 8'h80);
    hread(3'd0, rv); check("R7 write one no set", {8'h0, rv}, 16'h003F);

    // R8 enable gating
    bus_cyc(16'h0100, 16'h0, 1, 0, 1, 2'd1);
    check("R8 disabled irq", {15'b0, irq}, 16'h0);
    hread(3'd0, rv); check("R8 flag w/o enable", {8'h0, rv}, 16'h00BF);
    hwrite(3'd0, 8'hC0);
    check("R8 enable raises irq", {15'b0, irq}, 16'h1);

    // R9 collision of hit and armed clear
    hread(3'd0, rv);
    @(negedge clk);
    hst_wr = 1; hst_addr = 3'd0; hst_wdata = 8'h40;
    bus_valid = 1; bus_addr = 16'h0100; bus_word = 1; bus_write = 0;
    bus_fetch = 1; bus_space = 2'd0;
    @(negedge clk);
    hst_wr = 0; bus_valid = 0;
    check("R9 set wins irq", {15'b0, irq}, 16'h1);
    hwrite(3'd0, 8'h40);
    check("R9 arm spent", {15'b0, irq}, 16'h1);
    hread(3'd0, rv); check("R9 flag kept", {8'h0, rv}, 16'h00FF);
    hwrite(3'd0, 8'h40);
    hread(3'd0, rv); check("R9 later clear", {8'h0, rv}, 16'h007F);

    // R3 R4 R5 sweep
    hwrite(3'd4, 8'hA5);
    hwrite(3'd5, 8'h5A);
    for (int cs = 0; cs < 4; cs++) begin
      for (int dm = 0; dm < 4; dm++) begin
        hwrite(3'd1, 8'((dm << 2) | cs));
        for (int bp = 0; bp < 2; bp++) begin
          set_bar(16'h1234 | 16'(bp));
          for (int ty = 0; ty < 3; ty++) begin
            for (int sp = 0; sp < 4; sp++) begin
              for (int w = 0; w < 2; w++) begin
                for (int av = 0; av < 2; av++) begin
                  for (int dv = 0; dv < 3; dv++) begin
                    logic [15:0] bar, a, d;
                    logic f, wr, e;
                    bar = 16'h1234 | 16'(bp);
                    a = bar ^ 16'(av);
                    d = (dv == 0) ? 16'hA55A : (dv == 1) ? 16'h5A5A : 16'hA5A5;
                    f = (ty == 0);
                    wr = (ty == 2);
                    e = exp_hit(2'(cs), 2'(dm), bar, 16'hA55A, a, d, 1'(w), wr, f, 2'(sp));
                    clear_flag(8'h40);
                    bus_cyc(a, d, 1'(w), wr, f, 2'(sp));
                    check("R3 R4 R5 sweep irq", {15'b0, irq}, {15'b0, e});
                    hread(3'd0, rv);
                    check("R3 R4 R5 sweep flag", {8'h0, rv}, e ? 16'h00FF : 16'h007F);
                  end
                end
              end
            end
          end
        end
      end
    end

    // R4 far address never hits
    hwrite(3'd1, 8'h03);
    set_bar(16'h4000);
    clear_flag(8'h40);
    bus_cyc(16'h4100, 16'h0, 0, 0, 0, 2'd1);
    hread(3'd0, rv); check("R4 far miss", {8'h0, rv}, 16'h007F);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule